// File: doc/BRIEF.md
# Block Ownership Coherency Controller

This controller sits between memory requesters (a caching processor and I/O agents) and a word-wide backing memory. It keeps one ownership flag and the owning requester's ID for every 32-byte block of the address space. A requester that takes a block for writing with a read-for-ownership becomes its owner. Until the owner hands the block back with a disown write, reads and writes to that block from other requesters are held in a small parking table. This keeps memory coherent with the owner's cache and gives processor and I/O software a hardware interlock on shared data.

Requests enter on a valid/ready stream, and every accepted request produces exactly one response on a second valid/ready stream, with one exception: a parked request is answered only later, when it is served or times out. The engine handles one operation at a time. `req_ready` is low while a response waits for `rsp_ready`, while a memory read is in flight, and while a parked entry is due for service or expiry. A response stays on the port unchanged until the consumer takes it. The backing memory port returns read data one cycle after `mem_en`. The parking timeout is a cycle count on the plain input `tmo_cycles`, sampled each time a request is parked.

Top module: `own_coherency_ctrl`

## Requirements
- R1: A request transfers only on a cycle with `req_valid` and `req_ready` both high. A response held by `rsp_ready` low keeps `rsp_valid`, `rsp_code`, `rsp_id` and `rsp_data` stable, and no new request is accepted while it waits.
- R2: A read (`req_cmd` 0) to a block that is unowned or owned by the same requester returns the addressed memory word in `rsp_data` with code 0 (OK).
- R3: A read-for-ownership (`req_cmd` 1) to a block not owned by another requester returns the memory word with code 0 and makes the requester the owner. A later request to that block from another ID is parked.
- R4: A write (`req_cmd` 2) to a block not owned by another requester writes memory and answers code 0 with data 0. Byte enables follow `req_size`: 0 is a byte on lane `addr[1:0]`, 1 is a halfword on lanes 1:0 or 3:2 chosen by `addr[1]`, 2 is the full word. Write data sits in its byte lanes of `req_wdata`.
- R5: A read, read-for-ownership or write to a block owned by another ID gets no response while parked. When the owner disowns the block, the parked request is served against the updated memory and answered code 0.
- R6: A disown write (`req_cmd` 3) from the owner writes its data, clears the block's ownership and answers code 0. To a block that is unowned or owned by another ID, it answers code 4, leaves memory unchanged and leaves ownership unchanged.
- R7: At most one request per block is parked. A second blocked request to the same block, or any blocked request while all `PARK_N` entries are in use, is answered code 1 (retry).
- R8: A parked request not served within `tmo_cycles` cycles of being parked is dropped. A read or read-for-ownership answers code 5, and a write answers code 6 without writing memory.
- R9: Commands 4 to 7 are reserved. They are answered code 2, with no memory access and no ownership change.
- R10: An illegal length is answered code 3 with no memory access. Illegal means `req_size` 3, a halfword at an odd address, or a word not 4-byte aligned. The command check comes before the length check.
- R11: After reset no block is owned, no request is parked, `rsp_valid` and `mem_en` are low and `req_ready` is high.
- R12: Ownership covers exactly one 32-byte block (`addr[ADDR_W-1:5]`). Every address inside an owned block is held back, and the adjacent block is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmo_cycles | input | TMO_W | Parking timeout in cycles, loaded at each park |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_cmd | input | 3 | 0 read, 1 read-for-ownership, 2 write, 3 disown write, 4-7 reserved |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_addr | input | ADDR_W | Byte address |
| req_id | input | ID_W | Requester ID |
| req_wdata | input | 32 | Write data in byte lanes |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_code | output | 3 | 0 OK, 1 retry, 2 bad command, 3 bad length, 4 not owned, 5 read timeout, 6 write timeout |
| rsp_id | output | ID_W | ID of the request answered |
| rsp_data | output | 32 | Read word, zero otherwise |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read strobe |

## Verification
The bench builds the controller with `ADDR_W` 12, `ID_W` 2, `TMO_W` 16 and `PARK_N` 2. A two-entry table fills with three owned blocks, so a retry caused by a full table sits next to the retry caused by a second request to the same block. `tmo_cycles` is set to 200 while ownership hand-offs are exercised, so those parked requests are served rather than expired. It drops to 40 for the timeout case, so read and write expiries both show up within a few dozen cycles and in parking order. Four requester IDs allow an owner, a parked waiter and a retried third party at once.

// File: rtl/own_pkg.sv
package own_pkg;

  localparam logic [2:0] CMD_READ   = 3'd0;
  localparam logic [2:0] CMD_RDOWN  = 3'd1;
  localparam logic [2:0] CMD_WRITE  = 3'd2;
  localparam logic [2:0] CMD_DISOWN = 3'd3;

  typedef enum logic [2:0] {
    RC_OK       = 3'd0,
    RC_RETRY    = 3'd1,
    RC_BAD_CMD  = 3'd2,
    RC_BAD_LEN  = 3'd3,
    RC_NOT_OWN  = 3'd4,
    RC_TMO_RD   = 3'd5,
    RC_TMO_WR   = 3'd6
  } rsp_code_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RDATA = 2'd1,
    ST_RSP   = 2'd2
  } eng_state_e;

  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    lane_mask = 4'b0001 << lo;
      2'd1:    lane_mask = lo[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic size_bad(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    size_bad = 1'b0;
      2'd1:    size_bad = lo[0];
      2'd2:    size_bad = (lo != 2'd0);
      default: size_bad = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/own_bits.sv
module own_bits #(
  parameter int NBLK = 128,
  parameter int ID_W = 2,
  parameter int BLK_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       set_en,
  input  logic [BLK_W-1:0]           set_blk,
  input  logic [ID_W-1:0]            set_id,
  input  logic                       clr_en,
  input  logic [BLK_W-1:0]           clr_blk,
  output logic [NBLK-1:0]            owned_o,
  output logic [NBLK-1:0][ID_W-1:0]  owner_o
);

  logic [NBLK-1:0]           owned_q;
  logic [NBLK-1:0][ID_W-1:0] owner_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owned_q <= '0;
      owner_q <= '0;
    end else begin
      if (set_en) begin
        owned_q[set_blk] <= 1'b1;
        owner_q[set_blk] <= set_id;
      end
      if (clr_en) owned_q[clr_blk] <= 1'b0;
    end
  end

  assign owned_o = owned_q;
  assign owner_o = owner_q;

  // R6: the engine only clears a flag that is currently set
  p_clr_only_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> owned_q[clr_blk]);

  // R6: a cleared block reads as unowned on the next cycle
  p_clr_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !owned_q[$past(clr_blk)]);

  // R3: a taken block reads as owned by the taker on the next cycle
  p_set_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> (owned_q[$past(set_blk)] && owner_q[$past(set_blk)] == $past(set_id)));

endmodule

// File: rtl/own_park.sv
module own_park #(
  parameter int PARK_N = 2,
  parameter int ADDR_W = 12,
  parameter int ID_W = 2,
  parameter int TMO_W = 16,
  parameter int BLK_W = 7,
  parameter int IDX_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  tmo_load,
  input  logic              park_en,
  input  logic [2:0]        park_cmd,
  input  logic [1:0]        park_size,
  input  logic [ADDR_W-1:0] park_addr,
  input  logic [ID_W-1:0]   park_id,
  input  logic [31:0]       park_wdata,
  input  logic              free_en,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic [BLK_W-1:0]  q_blk,
  output logic              q_hit,
  output logic              full,
  output logic [PARK_N-1:0] vld_o,
  output logic [PARK_N-1:0] exp_o,
  output logic [2:0]        e_cmd   [PARK_N],
  output logic [1:0]        e_size  [PARK_N],
  output logic [ADDR_W-1:0] e_addr  [PARK_N],
  output logic [ID_W-1:0]   e_id    [PARK_N],
  output logic [31:0]       e_wdata [PARK_N]
);

  logic [PARK_N-1:0] vld_q;
  logic [TMO_W-1:0]  tmr_q [PARK_N];
  logic [IDX_W-1:0]  slot;

  always_comb begin
    slot = '0;
    for (int i = PARK_N - 1; i >= 0; i--)
      if (!vld_q[i]) slot = IDX_W'(i);
  end

  always_comb begin
    q_hit = 1'b0;
    for (int i = 0; i < PARK_N; i++)
      if (vld_q[i] && e_addr[i][ADDR_W-1:5] == q_blk) q_hit = 1'b1;
  end

  assign full  = &vld_q;
  assign vld_o = vld_q;

  genvar g;
  generate
    for (g = 0; g < PARK_N; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[g]   <= 1'b0;
          tmr_q[g]   <= '0;
          e_cmd[g]   <= '0;
          e_size[g]  <= '0;
          e_addr[g]  <= '0;
          e_id[g]    <= '0;
          e_wdata[g] <= '0;
        end else if (park_en && slot == IDX_W'(g)) begin
          vld_q[g]   <= 1'b1;
          tmr_q[g]   <= tmo_load;
          e_cmd[g]   <= park_cmd;
          e_size[g]  <= park_size;
          e_addr[g]  <= park_addr;
          e_id[g]    <= park_id;
          e_wdata[g] <= park_wdata;
        end else if (free_en && free_idx == IDX_W'(g)) begin
          vld_q[g] <= 1'b0;
        end else if (vld_q[g] && tmr_q[g] != '0) begin
          tmr_q[g] <= tmr_q[g] - 1'b1;
        end
      end
      assign exp_o[g] = vld_q[g] && (tmr_q[g] == '0);
    end
  endgenerate

  // R7: never a second parked request for one block
  p_one_per_blk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |-> !q_hit);

  // R7: never park into a full table
  p_no_park_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |-> !full);

  // R8: only occupied entries are released
  p_free_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> vld_q[free_idx]);

endmodule

// File: rtl/own_coherency_ctrl.sv
module own_coherency_ctrl
  import own_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ID_W = 2,
  parameter int TMO_W = 16,
  parameter int PARK_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  tmo_cycles,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_cmd,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_code,
  output logic [ID_W-1:0]   rsp_id,
  output logic [31:0]       rsp_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);

  localparam int BLK_W = ADDR_W - 5;
  localparam int NBLK  = 1 << BLK_W;
  localparam int IDX_W = (PARK_N > 1) ? $clog2(PARK_N) : 1;

  eng_state_e state_q, state_d;

  logic [NBLK-1:0]           owned_v;
  logic [NBLK-1:0][ID_W-1:0] owner_v;
  logic                      set_en, clr_en;
  logic [BLK_W-1:0]          a_blk;

  logic              park_en, free_en, q_hit, p_full;
  logic [IDX_W-1:0]  free_idx;
  logic [PARK_N-1:0] p_vld, p_exp, p_rdy;
  logic [2:0]        e_cmd   [PARK_N];
  logic [1:0]        e_size  [PARK_N];
  logic [ADDR_W-1:0] e_addr  [PARK_N];
  logic [ID_W-1:0]   e_id    [PARK_N];
  logic [31:0]       e_wdata [PARK_N];

  logic [BLK_W-1:0]  n_blk;
  logic              n_other, n_mine;

  logic              rdy_any, exp_any;
  logic [IDX_W-1:0]  rdy_idx, exp_idx;

  logic [2:0]        a_cmd;
  logic [1:0]        a_size;
  logic [ADDR_W-1:0] a_addr;
  logic [ID_W-1:0]   a_id;
  logic [31:0]       a_wdata;
  logic              do_op;

  logic              ld_rsp, ld_id;
  rsp_code_e         ld_code;
  logic [ID_W-1:0]   ld_idv;
  logic [31:0]       ld_data;

  rsp_code_e         code_q;
  logic [ID_W-1:0]   id_q;
  logic [31:0]       data_q;
  logic [2:0]        cur_cmd_q;
  logic [BLK_W-1:0]  cur_blk_q;

  own_bits #(.NBLK(NBLK), .ID_W(ID_W), .BLK_W(BLK_W)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_blk(a_blk), .set_id(a_id),
    .clr_en(clr_en), .clr_blk(a_blk),
    .owned_o(owned_v), .owner_o(owner_v)
  );

  own_park #(.PARK_N(PARK_N), .ADDR_W(ADDR_W), .ID_W(ID_W), .TMO_W(TMO_W),
             .BLK_W(BLK_W), .IDX_W(IDX_W)) u_park (
    .clk(clk), .rst_n(rst_n), .tmo_load(tmo_cycles),
    .park_en(park_en), .park_cmd(req_cmd), .park_size(req_size),
    .park_addr(req_addr), .park_id(req_id), .park_wdata(req_wdata),
    .free_en(free_en), .free_idx(free_idx),
    .q_blk(n_blk), .q_hit(q_hit), .full(p_full),
    .vld_o(p_vld), .exp_o(p_exp),
    .e_cmd(e_cmd), .e_size(e_size), .e_addr(e_addr), .e_id(e_id), .e_wdata(e_wdata)
  );

  // parked entries become serviceable once their block is free for them
  always_comb begin
    logic [BLK_W-1:0] pb;
    for (int i = 0; i < PARK_N; i++) begin
      pb = e_addr[i][ADDR_W-1:5];
      p_rdy[i] = p_vld[i] && !(owned_v[pb] && owner_v[pb] != e_id[i]);
    end
    rdy_any = |p_rdy;
    exp_any = |p_exp;
    rdy_idx = '0;
    exp_idx = '0;
    for (int i = PARK_N - 1; i >= 0; i--) begin
      if (p_rdy[i]) rdy_idx = IDX_W'(i);
      if (p_exp[i]) exp_idx = IDX_W'(i);
    end
  end

  assign n_blk   = req_addr[ADDR_W-1:5];
  assign n_other = owned_v[n_blk] && owner_v[n_blk] != req_id;
  assign n_mine  = owned_v[n_blk] && owner_v[n_blk] == req_id;

  assign req_ready = (state_q == ST_IDLE) && !rdy_any && !exp_any;

  always_comb begin
    if (rdy_any) begin
      a_cmd   = e_cmd[rdy_idx];
      a_size  = e_size[rdy_idx];
      a_addr  = e_addr[rdy_idx];
      a_id    = e_id[rdy_idx];
      a_wdata = e_wdata[rdy_idx];
    end else begin
      a_cmd   = req_cmd;
      a_size  = req_size;
      a_addr  = req_addr;
      a_id    = req_id;
      a_wdata = req_wdata;
    end
  end
  assign a_blk = a_addr[ADDR_W-1:5];

  always_comb begin
    state_d   = state_q;
    do_op     = 1'b0;
    park_en   = 1'b0;
    free_en   = 1'b0;
    free_idx  = rdy_idx;
    ld_rsp    = 1'b0;
    ld_id     = 1'b0;
    ld_code   = RC_OK;
    ld_idv    = a_id;
    ld_data   = '0;
    set_en    = 1'b0;
    clr_en    = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = a_addr[ADDR_W-1:2];
    mem_be    = lane_mask(a_size, a_addr[1:0]);
    mem_wdata = a_wdata;
    case (state_q)
      ST_IDLE: begin
        if (rdy_any) begin
          free_en = 1'b1;
          do_op   = 1'b1;
        end else if (exp_any) begin
          free_en  = 1'b1;
          free_idx = exp_idx;
          ld_rsp   = 1'b1;
          ld_idv   = e_id[exp_idx];
          ld_code  = (e_cmd[exp_idx] == CMD_WRITE) ? RC_TMO_WR : RC_TMO_RD;
        end else if (req_valid) begin
          if (req_cmd[2]) begin
            ld_rsp  = 1'b1;
            ld_code = RC_BAD_CMD;
          end else if (size_bad(req_size, req_addr[1:0])) begin
            ld_rsp  = 1'b1;
            ld_code = RC_BAD_LEN;
          end else if (req_cmd == CMD_DISOWN) begin
            if (n_mine) do_op = 1'b1;
            else begin
              ld_rsp  = 1'b1;
              ld_code = RC_NOT_OWN;
            end
          end else if (n_other) begin
            if (q_hit || p_full) begin
              ld_rsp  = 1'b1;
              ld_code = RC_RETRY;
            end else begin
              park_en = 1'b1;
            end
          end else begin
            do_op = 1'b1;
          end
        end
        if (do_op) begin
          mem_en = 1'b1;
          ld_id  = 1'b1;
          if (a_cmd == CMD_READ || a_cmd == CMD_RDOWN) begin
            state_d = ST_RDATA;
            set_en  = (a_cmd == CMD_RDOWN);
          end else begin
            mem_we = 1'b1;
            clr_en = (a_cmd == CMD_DISOWN);
            ld_rsp = 1'b1;
          end
        end
        if (ld_rsp) state_d = ST_RSP;
      end
      ST_RDATA: begin
        ld_rsp  = 1'b1;
        ld_idv  = id_q;
        ld_data = mem_rdata;
        state_d = ST_RSP;
      end
      default: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      code_q    <= RC_OK;
      id_q      <= '0;
      data_q    <= '0;
      cur_cmd_q <= '0;
      cur_blk_q <= '0;
    end else begin
      state_q <= state_d;
      if (ld_id) begin
        id_q      <= a_id;
        cur_cmd_q <= a_cmd;
        cur_blk_q <= a_blk;
      end
      if (ld_rsp) begin
        code_q <= ld_code;
        id_q   <= ld_idv;
        data_q <= ld_data;
      end
    end
  end

  assign rsp_valid = (state_q == ST_RSP);
  assign rsp_code  = code_q;
  assign rsp_id    = id_q;
  assign rsp_data  = data_q;

  // R1: a stalled response holds its contents
  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_id) && $stable(rsp_data)));

  // R1: no request taken while a response waits
  p_no_take_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R5: memory is never touched on behalf of a blocked requester
  p_mem_not_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !(owned_v[mem_addr[ADDR_W-3:3]] && owner_v[mem_addr[ADDR_W-3:3]] != a_id));

  // R3: while a read-for-ownership waits for data the block is already held
  p_rdown_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RDATA && cur_cmd_q == CMD_RDOWN) |-> owned_v[cur_blk_q]);

  // R9, R10: rejected commands or lengths reach neither memory nor the table
  p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_cmd[2] || size_bad(req_size, req_addr[1:0]))) |-> (!mem_en && !park_en));

endmodule

// File: tb/own_coherency_ctrl_bench.sv
module own_coherency_ctrl_bench;

  localparam int ADDR_W = 12;
  localparam int ID_W   = 2;
  localparam int TMO_W  = 16;
  localparam int PARK_N = 2;
  localparam int WORDS  = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TMO_W-1:0]  tmo_cycles = 16'd200;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_cmd = '0;
  logic [1:0]        req_size = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [ID_W-1:0]   req_id = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [2:0]        rsp_code;
  logic [ID_W-1:0]   rsp_id;
  logic [31:0]       rsp_data;
  logic              mem_en, mem_we;
  logic [ADDR_W-3:0] mem_addr;
  logic [3:0]        mem_be;
  logic [31:0]       mem_wdata;
  logic [31:0]       mem_rdata = '0;

  always #4 clk = ~clk;

  own_coherency_ctrl #(.ADDR_W(ADDR_W), .ID_W(ID_W), .TMO_W(TMO_W), .PARK_N(PARK_N)) u_own_coherency_ctrl (
    .clk(clk), .rst_n(rst_n), .tmo_cycles(tmo_cycles),
    .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd), .req_size(req_size),
    .req_addr(req_addr), .req_id(req_id), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_id(rsp_id),
    .rsp_data(rsp_data), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // backing memory: one-cycle read latency
  logic [31:0] mem_m   [WORDS];
  logic [31:0] ref_mem [WORDS];
  initial begin
    for (int i = 0; i < WORDS; i++) begin
      mem_m[i]   = 32'h5A00_0000 ^ (i * 32'h0001_0003);
      ref_mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0003);
    end
  end
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem_m[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
      mem_rdata <= mem_m[mem_addr];
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit stall = 1'b0;
  bit done = 1'b0;

  logic [2:0]      q_code [$];
  logic [ID_W-1:0] q_id   [$];
  logic [31:0]     q_data [$];
  string           q_tag  [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_rsp(input logic [2:0] c, input logic [ID_W-1:0] i, input logic [31:0] d, input string tag);
    q_code.push_back(c);
    q_id.push_back(i);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  function automatic logic [31:0] rd_ref(input logic [ADDR_W-1:0] a);
    return ref_mem[a[ADDR_W-1:2]];
  endfunction

  // R4 lane rule applied to the bench's own copy
  task automatic ref_write(input logic [1:0] s, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [3:0] be;
    if (s == 2'd0) be = 4'b0001 << a[1:0];
    else if (s == 2'd1) be = a[1] ? 4'b1100 : 4'b0011;
    else be = 4'b1111;
    for (int b = 0; b < 4; b++)
      if (be[b]) ref_mem[a[ADDR_W-1:2]][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic send(input logic [2:0] c, input logic [1:0] s, input logic [ADDR_W-1:0] a,
                      input logic [ID_W-1:0] i, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_cmd = c; req_size = s; req_addr = a; req_id = i; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400 && q_code.size() != 0; k++) @(negedge clk);
    chk(q_code.size() == 0, "R1 responses outstanding", q_code.size(), 0);
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    rsp_ready = !stall;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (q_code.size() == 0) begin
        chk(1'b0, "R1 unexpected response", {29'd0, rsp_code}, 32'hFFFF_FFFF);
      end else begin
        string t;
        logic [2:0] c;
        logic [ID_W-1:0] i;
        logic [31:0] d;
        c = q_code.pop_front(); i = q_id.pop_front(); d = q_data.pop_front(); t = q_tag.pop_front();
        chk(rsp_code == c, {t, " code"}, {29'd0, rsp_code}, {29'd0, c});
        chk(rsp_id == i, {t, " id"}, {30'd0, rsp_id}, {30'd0, i});
        chk(rsp_data == d, {t, " data"}, rsp_data, d);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R11 req_ready after reset", req_ready, 1);
    chk(mem_en == 1'b0, "R11 mem_en after reset", mem_en, 0);

    // R2 plain reads, R11 nothing owned after reset
    expect_rsp(3'd0, 2'd0, rd_ref(12'h040), "R2 read word");
    send(3'd0, 2'd2, 12'h040, 2'd0, 0);
    expect_rsp(3'd0, 2'd3, rd_ref(12'h102), "R11 read unowned halfword");
    send(3'd0, 2'd1, 12'h102, 2'd3, 0);

    // R4 byte write then readback
    ref_write(2'd0, 12'h045, 32'h0000_AB00);
    expect_rsp(3'd0, 2'd0, 0, "R4 byte write");
    send(3'd2, 2'd0, 12'h045, 2'd0, 32'h0000_AB00);
    ref_write(2'd1, 12'h04A, 32'hBEEF_0000);
    expect_rsp(3'd0, 2'd0, 0, "R4 upper halfword write");
    send(3'd2, 2'd1, 12'h04A, 2'd0, 32'hBEEF_0000);
    expect_rsp(3'd0, 2'd1, rd_ref(12'h044), "R4 readback byte lane");
    send(3'd0, 2'd2, 12'h044, 2'd1, 0);
    expect_rsp(3'd0, 2'd1, rd_ref(12'h048), "R4 readback half lanes");
    send(3'd0, 2'd2, 12'h048, 2'd1, 0);

    // R10 illegal lengths, R9 reserved commands
    expect_rsp(3'd3, 2'd0, 0, "R10 size 3");
    send(3'd2, 2'd3, 12'h044, 2'd0, 32'hFFFF_FFFF);
    expect_rsp(3'd3, 2'd0, 0, "R10 misaligned word");
    send(3'd2, 2'd2, 12'h046, 2'd0, 32'hFFFF_FFFF);
    expect_rsp(3'd3, 2'd0, 0, "R10 odd halfword");
    send(3'd0, 2'd1, 12'h041, 2'd0, 0);
    expect_rsp(3'd2, 2'd2, 0, "R9 reserved cmd 5");
    send(3'd5, 2'd2, 12'h044, 2'd2, 32'hFFFF_FFFF);
    expect_rsp(3'd2, 2'd2, 0, "R9 reserved cmd 7 before length");
    send(3'd7, 2'd3, 12'h045, 2'd2, 32'hFFFF_FFFF);
    expect_rsp(3'd0, 2'd0, rd_ref(12'h044), "R10 memory untouched");
    send(3'd0, 2'd2, 12'h044, 2'd0, 0);

    // R6 disown of unowned block
    expect_rsp(3'd4, 2'd0, 0, "R6 disown unowned");
    send(3'd3, 2'd2, 12'h040, 2'd0, 32'h1111_1111);
    expect_rsp(3'd0, 2'd0, rd_ref(12'h040), "R6 memory untouched");
    send(3'd0, 2'd2, 12'h040, 2'd0, 0);
    drain();

    // R3 take block A, R12/R5 park a read at the last word of A
    tmo_cycles = 16'd200;
    expect_rsp(3'd0, 2'd1, rd_ref(12'h040), "R3 read-for-ownership");
    send(3'd1, 2'd2, 12'h040, 2'd1, 0);
    send(3'd0, 2'd2, 12'h05C, 2'd2, 0);
    repeat (10) @(negedge clk);
    chk(q_code.size() == 0 && !rsp_valid, "R5 no response while parked", rsp_valid, 0);
    expect_rsp(3'd0, 2'd2, rd_ref(12'h060), "R12 adjacent block free");
    send(3'd0, 2'd2, 12'h060, 2'd2, 0);
    expect_rsp(3'd1, 2'd3, 0, "R7 second request same block");
    send(3'd0, 2'd2, 12'h048, 2'd3, 0);
    expect_rsp(3'd4, 2'd2, 0, "R6 disown by non-owner");
    send(3'd3, 2'd2, 12'h040, 2'd2, 32'h2222_2222);
    expect_rsp(3'd0, 2'd1, rd_ref(12'h040), "R2 owner reads own block");
    send(3'd0, 2'd2, 12'h040, 2'd1, 0);
    ref_write(2'd2, 12'h05C, 32'hC0DE_0001);
    expect_rsp(3'd0, 2'd1, 0, "R6 owner disown");
    send(3'd3, 2'd2, 12'h05C, 2'd1, 32'hC0DE_0001);
    expect_rsp(3'd0, 2'd2, rd_ref(12'h05C), "R5 parked read served");
    drain();

    // R5 parked write released by disown
    expect_rsp(3'd0, 2'd1, rd_ref(12'h080), "R3 take block B");
    send(3'd1, 2'd2, 12'h080, 2'd1, 0);
    send(3'd2, 2'd2, 12'h084, 2'd2, 32'h7777_0084);
    ref_write(2'd2, 12'h080, 32'h9999_0080);
    expect_rsp(3'd0, 2'd1, 0, "R6 disown B");
    send(3'd3, 2'd2, 12'h080, 2'd1, 32'h9999_0080);
    ref_write(2'd2, 12'h084, 32'h7777_0084);
    expect_rsp(3'd0, 2'd2, 0, "R5 parked write served");
    drain();
    expect_rsp(3'd0, 2'd0, rd_ref(12'h084), "R5 parked write landed");
    send(3'd0, 2'd2, 12'h084, 2'd0, 0);
    expect_rsp(3'd0, 2'd0, rd_ref(12'h080), "R6 disown data landed");
    send(3'd0, 2'd2, 12'h080, 2'd0, 0);
    drain();

    // R7 full table and R8 timeouts
    tmo_cycles = 16'd40;
    expect_rsp(3'd0, 2'd1, rd_ref(12'h040), "R3 take A");
    send(3'd1, 2'd2, 12'h040, 2'd1, 0);
    expect_rsp(3'd0, 2'd1, rd_ref(12'h080), "R3 take B");
    send(3'd1, 2'd2, 12'h080, 2'd1, 0);
    expect_rsp(3'd0, 2'd1, rd_ref(12'h0C0), "R3 take C");
    send(3'd1, 2'd2, 12'h0C0, 2'd1, 0);
    send(3'd0, 2'd2, 12'h040, 2'd2, 0);
    send(3'd2, 2'd2, 12'h084, 2'd2, 32'hDEAD_DEAD);
    expect_rsp(3'd1, 2'd3, 0, "R7 table full");
    send(3'd0, 2'd2, 12'h0C0, 2'd3, 0);
    expect_rsp(3'd5, 2'd2, 0, "R8 read timeout");
    expect_rsp(3'd6, 2'd2, 0, "R8 write timeout");
    drain();
    expect_rsp(3'd0, 2'd1, rd_ref(12'h084), "R8 timed-out write dropped");
    send(3'd0, 2'd2, 12'h084, 2'd1, 0);
    ref_write(2'd2, 12'h040, 32'hA0A0_0040);
    expect_rsp(3'd0, 2'd1, 0, "R6 release A");
    send(3'd3, 2'd2, 12'h040, 2'd1, 32'hA0A0_0040);
    ref_write(2'd2, 12'h080, 32'hB0B0_0080);
    expect_rsp(3'd0, 2'd1, 0, "R6 release B");
    send(3'd3, 2'd2, 12'h080, 2'd1, 32'hB0B0_0080);
    ref_write(2'd2, 12'h0C0, 32'hC0C0_00C0);
    expect_rsp(3'd0, 2'd1, 0, "R6 release C");
    send(3'd3, 2'd2, 12'h0C0, 2'd1, 32'hC0C0_00C0);
    drain();

    // R1 back-pressure on the response port
    stall = 1'b1;
    d = rd_ref(12'h100);
    send(3'd0, 2'd2, 12'h100, 2'd0, 0);
    repeat (6) @(negedge clk);
    chk(rsp_valid == 1'b1, "R1 stalled valid", rsp_valid, 1);
    chk(rsp_data == d, "R1 stalled data", rsp_data, d);
    chk(req_ready == 1'b0, "R1 no intake while stalled", req_ready, 0);
    expect_rsp(3'd0, 2'd0, d, "R1 released response");
    stall = 1'b0;
    drain();

    // R3 ownership passes to a parked read-for-ownership
    tmo_cycles = 16'd200;
    expect_rsp(3'd0, 2'd1, rd_ref(12'h140), "R3 take D");
    send(3'd1, 2'd2, 12'h140, 2'd1, 0);
    send(3'd1, 2'd2, 12'h144, 2'd2, 0);
    ref_write(2'd2, 12'h140, 32'h0D0D_0140);
    expect_rsp(3'd0, 2'd1, 0, "R6 disown D");
    send(3'd3, 2'd2, 12'h140, 2'd1, 32'h0D0D_0140);
    expect_rsp(3'd0, 2'd2, rd_ref(12'h144), "R3 parked ownership served");
    drain();
    send(3'd0, 2'd2, 12'h148, 2'd3, 0);
    repeat (8) @(negedge clk);
    chk(q_code.size() == 0 && !rsp_valid, "R3 new owner blocks others", rsp_valid, 0);
    ref_write(2'd2, 12'h148, 32'h0E0E_0148);
    expect_rsp(3'd0, 2'd2, 0, "R3 new owner disowns");
    send(3'd3, 2'd2, 12'h148, 2'd2, 32'h0E0E_0148);
    expect_rsp(3'd0, 2'd3, rd_ref(12'h148), "R5 third party served");
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule